// File: doc/BRIEF.md
# Auto-Negotiation Link Pulse Generator

This block produces the logical pulse train a twisted-pair Ethernet port sends on an idle line so that its link partner can see it. With auto-negotiation on, each transmit interval opens with a burst of fast link pulses. Seventeen clock pulses are spaced one slot apart. Between consecutive clock pulses sits an optional data pulse half a slot after the clock pulse, one per bit of a 16-bit code word. With auto-negotiation off, each interval carries just one normal link pulse. All widths, spacings and the interval length are counted in reference clock cycles and set by parameters.

A controller drives `start_i` high to run the generator and low to silence it. The code word and the mode are taken at the first cycle of every interval, so the controller may update them at any time. A one-cycle strobe marks the end of each burst. A small combinational helper turns two configuration straps into the 4-bit advertised ability field, which a controller can place into the code word.

Top module: `link_pulse_gen`

## Requirements
- R1: While `rst_ni` is low, and afterwards until `start_i` is sampled high, `pulse_o` and `done_o` stay low.
- R2: In auto-negotiation mode, every interval holds 17 clock pulses, each `PULSE_CYC` cycles high, starting at offsets s*`SLOT_CYC` (s = 0..16) from the interval start.
- R3: In auto-negotiation mode, code word bit s (s = 0..15, bit 0 first) equal to 1 adds a `PULSE_CYC`-wide pulse at offset s*`SLOT_CYC`+`HALF_CYC`; a 0 bit adds nothing.
- R4: The first interval starts at the rising edge that samples `start_i` high, and `pulse_o` follows that interval's schedule one cycle later. Intervals then repeat back to back every `INTERVAL_CYC` cycles while `start_i` stays high.
- R5: With auto-negotiation off, each interval holds a single `PULSE_CYC`-wide pulse at offset 0 and no other pulse.
- R6: `done_o` is high for exactly one cycle: the cycle right after the last clock pulse of a burst ends. It never rises with auto-negotiation off.
- R7: `code_word_i` is captured only at the first cycle of each interval; changes at other times do not alter the burst in progress.
- R8: `an_en_i` is taken only at the first cycle of each interval; a change mid-interval takes effect at the next interval.
- R9: After a rising edge samples `start_i` low, `pulse_o` and `done_o` are low from the next rising edge on, and stay low until `start_i` returns high. A later start opens a new interval at offset 0.
- R10: `ability_o` bits are {100BASE-TX full, 100BASE-TX half, 10BASE-T full, 10BASE-T half} (bit 3 down to bit 0). With `an_en_i` high, `strap_i` 00 gives 0011, 01 gives 1100, 10 gives 0101 and 11 gives 1111. With `an_en_i` low it is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| an_en_i | input | 1 | 1 selects fast-link-pulse bursts, 0 selects normal link pulses |
| strap_i | input | 2 | Configuration straps selecting the advertised ability set |
| code_word_i | input | WORD_W | Link code word sent in each burst, bit 0 first |
| start_i | input | 1 | Run enable for the pulse schedule |
| pulse_o | output | 1 | Logical link pulse stream |
| done_o | output | 1 | One-cycle strobe after the last clock pulse of a burst |
| ability_o | output | 4 | Advertised ability field built from the straps |

## Verification
The interval length in the bench is chosen so that the end-of-burst strobe falls in the very cycle in which the next interval captures its code word and mode. The bench changes `code_word_i` to a new value one cycle before that capture edge, after it had also changed the word mid-burst. It then checks two things: that `done_o` still pulses once, and that the following burst carries exactly the newly presented word and not the mid-burst value. Mode switches presented mid-interval are judged the same way, by comparing the full pulse trace of both intervals against a model built from the timing requirements.

// File: rtl/lpg_pkg.sv
package lpg_pkg;

  typedef enum logic {
    MODE_NLP = 1'b0,
    MODE_FLP = 1'b1
  } lp_mode_e;

  typedef struct packed {
    logic fd100;
    logic hd100;
    logic fd10;
    logic hd10;
  } ability_t;

  function automatic ability_t strap_to_ability(input logic [1:0] strap);
    ability_t a;
    a = '0;
    case (strap)
      2'b00: begin a.hd10 = 1'b1; a.fd10 = 1'b1; end
      2'b01: begin a.hd100 = 1'b1; a.fd100 = 1'b1; end
      2'b10: begin a.hd10 = 1'b1; a.hd100 = 1'b1; end
      default: a = '1;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/lpg_adv.sv
module lpg_adv
  import lpg_pkg::*;
(
  input  logic       an_en_i,
  input  logic [1:0] strap_i,
  output ability_t   ability_o
);

  always_comb begin
    ability_o = '0;
    if (an_en_i) ability_o = strap_to_ability(strap_i);
  end

endmodule

// File: rtl/lpg_sched.sv
module lpg_sched
  import lpg_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int SLOT_CYC     = 3125,
  parameter int INTERVAL_CYC = 400000,
  localparam int NUM_CLK     = WORD_W + 1,
  localparam int IC_W        = $clog2(INTERVAL_CYC),
  localparam int PH_W        = $clog2(SLOT_CYC),
  localparam int SL_W        = $clog2(NUM_CLK + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              an_en_i,
  input  logic [WORD_W-1:0] code_word_i,
  output logic              run_o,
  output lp_mode_e          mode_o,
  output logic [WORD_W-1:0] word_o,
  output logic [SL_W-1:0]   slot_o,
  output logic [PH_W-1:0]   phase_o
);

  logic [IC_W-1:0] ic_q;
  logic            wrap;

  assign wrap = (ic_q == IC_W'(INTERVAL_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o   <= 1'b0;
      mode_o  <= MODE_NLP;
      word_o  <= '0;
      ic_q    <= '0;
      slot_o  <= '0;
      phase_o <= '0;
    end else if (!start_i) begin
      run_o   <= 1'b0;
      ic_q    <= '0;
      slot_o  <= '0;
      phase_o <= '0;
    end else if (!run_o || wrap) begin
      // interval start: latch word and mode together
      run_o   <= 1'b1;
      ic_q    <= '0;
      slot_o  <= '0;
      phase_o <= '0;
      word_o  <= code_word_i;
      mode_o  <= an_en_i ? MODE_FLP : MODE_NLP;
    end else begin
      ic_q <= ic_q + 1'b1;
      if (phase_o == PH_W'(SLOT_CYC - 1)) begin
        phase_o <= '0;
        if (slot_o != SL_W'(NUM_CLK)) slot_o <= slot_o + 1'b1;
      end else begin
        phase_o <= phase_o + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lpg_shape.sv
module lpg_shape
  import lpg_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int SLOT_CYC  = 3125,
  parameter int PULSE_CYC = 3,
  parameter int HALF_CYC  = 1550,
  localparam int NUM_CLK  = WORD_W + 1,
  localparam int PH_W     = $clog2(SLOT_CYC),
  localparam int SL_W     = $clog2(NUM_CLK + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  lp_mode_e          mode_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [SL_W-1:0]   slot_i,
  input  logic [PH_W-1:0]   phase_i,
  output logic              pulse_o,
  output logic              done_o
);

  logic              flp;
  logic              in_clk_win;
  logic              in_dat_win;
  logic              clk_hit;
  logic              dat_hit;
  logic              done_hit;
  logic [WORD_W-1:0] word_sh;

  assign flp        = run_i && (mode_i == MODE_FLP);
  assign in_clk_win = phase_i < PH_W'(PULSE_CYC);
  assign in_dat_win = (phase_i >= PH_W'(HALF_CYC)) &&
                      (phase_i <  PH_W'(HALF_CYC + PULSE_CYC));
  assign word_sh    = word_i >> slot_i;

  always_comb begin
    if (flp) clk_hit = (slot_i < SL_W'(NUM_CLK)) && in_clk_win;
    else     clk_hit = run_i && (slot_i == '0) && in_clk_win;
  end

  assign dat_hit  = flp && (slot_i < SL_W'(WORD_W)) && word_sh[0] && in_dat_win;
  assign done_hit = flp && (slot_i == SL_W'(WORD_W)) && (phase_i == PH_W'(PULSE_CYC));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pulse_o <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      pulse_o <= clk_hit || dat_hit;
      done_o  <= done_hit;
    end
  end

endmodule

// File: rtl/link_pulse_gen.sv
module link_pulse_gen
  import lpg_pkg::*;
#(
  parameter int WORD_W       = 16,
  parameter int PULSE_CYC    = 3,
  parameter int SLOT_CYC     = 3125,
  parameter int HALF_CYC     = 1550,
  parameter int INTERVAL_CYC = 400000,
  localparam int NUM_CLK     = WORD_W + 1,
  localparam int PH_W        = $clog2(SLOT_CYC),
  localparam int SL_W        = $clog2(NUM_CLK + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              an_en_i,
  input  logic [1:0]        strap_i,
  input  logic [WORD_W-1:0] code_word_i,
  input  logic              start_i,
  output logic              pulse_o,
  output logic              done_o,
  output logic [3:0]        ability_o
);

  logic              run;
  lp_mode_e          mode;
  logic [WORD_W-1:0] word;
  logic [SL_W-1:0]   slot;
  logic [PH_W-1:0]   phase;
  ability_t          abil;

  lpg_sched #(
    .WORD_W      (WORD_W),
    .SLOT_CYC    (SLOT_CYC),
    .INTERVAL_CYC(INTERVAL_CYC)
  ) u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .an_en_i    (an_en_i),
    .code_word_i(code_word_i),
    .run_o      (run),
    .mode_o     (mode),
    .word_o     (word),
    .slot_o     (slot),
    .phase_o    (phase)
  );

  lpg_shape #(
    .WORD_W   (WORD_W),
    .SLOT_CYC (SLOT_CYC),
    .PULSE_CYC(PULSE_CYC),
    .HALF_CYC (HALF_CYC)
  ) u_shape (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .mode_i (mode),
    .word_i (word),
    .slot_i (slot),
    .phase_i(phase),
    .pulse_o(pulse_o),
    .done_o (done_o)
  );

  lpg_adv u_adv (
    .an_en_i  (an_en_i),
    .strap_i  (strap_i),
    .ability_o(abil)
  );

  assign ability_o = abil;

endmodule

// File: rtl/link_pulse_gen_chk.sv
module link_pulse_gen_chk #(
  parameter int PULSE_CYC = 3,
  localparam int CW       = $clog2(PULSE_CYC + 2)
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic       an_en_i,
  input logic [1:0] strap_i,
  input logic       pulse_o,
  input logic       done_o,
  input logic [3:0] ability_o
);

  logic [CW-1:0] hi_cnt;
  logic          start_q1;
  logic          start_q2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt   <= '0;
      start_q1 <= 1'b0;
      start_q2 <= 1'b0;
    end else begin
      start_q1 <= start_i;
      start_q2 <= start_q1;
      if (!pulse_o)                        hi_cnt <= '0;
      else if (hi_cnt != CW'(PULSE_CYC + 1)) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_PULSE_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_o && hi_cnt != '0 && start_q1 && start_q2) |-> hi_cnt == CW'(PULSE_CYC)); // R2

  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6

  AST_DONE_AFTER_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!pulse_o && $past(pulse_o))); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_q1 && !start_q2) |-> (!pulse_o && !done_o)); // R9

  AST_ABILITY_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !an_en_i |-> ability_o == 4'b0000); // R10

  AST_ABILITY_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (an_en_i && strap_i == 2'b11) |-> ability_o == 4'b1111); // R10

endmodule

bind link_pulse_gen link_pulse_gen_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .an_en_i  (an_en_i),
  .strap_i  (strap_i),
  .pulse_o  (pulse_o),
  .done_o   (done_o),
  .ability_o(ability_o)
);

// File: tb/link_pulse_gen_test.sv
module link_pulse_gen_test;

  localparam int PW   = 2;
  localparam int SLOT = 20;
  localparam int HALF = 10;
  localparam int INTV = 16 * SLOT + PW + 1;  // done lands on the capture cycle

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        an_en_i = 1'b0;
  logic [1:0]  strap_i = 2'b00;
  logic [15:0] code_word_i = '0;
  logic        start_i = 1'b0;
  logic        pulse_o;
  logic        done_o;
  logic [3:0]  ability_o;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  link_pulse_gen #(
    .WORD_W(16), .PULSE_CYC(PW), .SLOT_CYC(SLOT),
    .HALF_CYC(HALF), .INTERVAL_CYC(INTV)
  ) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .an_en_i(an_en_i), .strap_i(strap_i),
    .code_word_i(code_word_i), .start_i(start_i),
    .pulse_o(pulse_o), .done_o(done_o), .ability_o(ability_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  // schedule model from R2, R3, R5, R6
  task automatic model(input int e, input logic m, input logic [15:0] w,
                       output logic p, output logic d, output string r);
    int slot, ph;
    slot = e / SLOT;
    ph   = e % SLOT;
    if (m) begin
      p = 1'b0;
      r = "R2";
      if (slot <= 16 && ph < PW) p = 1'b1;
      if (slot <= 15 && ph >= HALF && ph < HALF + PW) begin
        r = "R3";
        if (w[slot]) p = 1'b1;
      end
      d = (e == 16 * SLOT + PW);
      if (d) r = "R6";
    end else begin
      p = (e < PW);
      d = 1'b0;
      r = "R5";
    end
  endtask

  // two intervals; word/mode changed mid-burst and right before the second capture
  task automatic run_trace(input string tag, input logic m0, input logic m1,
                           input logic [15:0] w0, input logic [15:0] wj,
                           input logic [15:0] w1);
    logic ep, ed;
    string r;
    an_en_i     = m0;
    code_word_i = w0;
    start_i     = 1'b1;
    for (int j = 1; j <= 2 * INTV + 1; j++) begin
      tick();
      if (j < 2) begin
        ep = 1'b0; ed = 1'b0; r = "R4";
      end else begin
        int ic, n;
        ic = j - 2;
        n  = ic / INTV;
        model(ic % INTV, (n == 0) ? m0 : m1, (n == 0) ? w0 : w1, ep, ed, r);
        if (n == 1) r = {r, " R4 R7 R8"};
      end
      check({tag, " pulse ", r}, pulse_o, ep);
      check({tag, " done ", r}, done_o, ed);
      if (j == 100) begin
        code_word_i = wj;
        an_en_i     = m1;
      end
      if (j == INTV) code_word_i = w1;
    end
    start_i = 1'b0;
    tick();
    tick();
  endtask

  task automatic test_reset();
    repeat (3) begin
      tick();
      check("R1 reset pulse", pulse_o, 0);
      check("R1 reset done", done_o, 0);
    end
    rst_ni = 1'b1;
    an_en_i = 1'b1;
    code_word_i = 16'hFFFF;
    repeat (10) begin
      tick();
      check("R1 idle pulse", pulse_o, 0);
      check("R1 idle done", done_o, 0);
    end
  endtask

  task automatic test_ability();
    for (int en = 0; en < 2; en++) begin
      for (int s = 0; s < 4; s++) begin
        logic [3:0] exp;
        an_en_i = en[0];
        strap_i = s[1:0];
        #1;
        if (en == 0)      exp = 4'b0000;
        else if (s == 0)  exp = 4'b0011;
        else if (s == 1)  exp = 4'b1100;
        else if (s == 2)  exp = 4'b0101;
        else              exp = 4'b1111;
        check("R10 ability", ability_o, exp);
      end
    end
    tick();
  endtask

  task automatic test_flp_basic();
    run_trace("R2 R3 R7 flp", 1'b1, 1'b1, 16'hA5C3, 16'hFFFF, 16'h8001);
  endtask

  task automatic test_flp_dense();
    run_trace("R3 dense", 1'b1, 1'b1, 16'hFFFF, 16'h1234, 16'h0000);
  endtask

  task automatic test_nlp();
    run_trace("R5 nlp", 1'b0, 1'b0, 16'hFFFF, 16'h0F0F, 16'hFFFF);
  endtask

  task automatic test_mode_switch();
    run_trace("R8 nlp to flp", 1'b0, 1'b1, 16'h0000, 16'hFFFF, 16'h5A5A);
    run_trace("R8 flp to nlp", 1'b1, 1'b0, 16'h3C3C, 16'h0000, 16'hFFFF);
  endtask

  task automatic test_stop();
    an_en_i     = 1'b1;
    code_word_i = 16'hFFFF;
    start_i     = 1'b1;
    tick();              // P1: interval opens
    tick();              // P2: first clock pulse on output
    check("R4 first pulse", pulse_o, 1);
    start_i = 1'b0;      // sampled low at P3
    tick();
    check("R9 pulse finishing", pulse_o, 1);
    repeat (3 * SLOT) begin
      tick();
      check("R9 stopped pulse", pulse_o, 0);
      check("R9 stopped done", done_o, 0);
    end
    code_word_i = 16'h0000;
    start_i = 1'b1;
    tick();
    check("R9 restart lag", pulse_o, 0);
    tick();
    check("R9 restart offset 0", pulse_o, 1);
    for (int k = 0; k < HALF; k++) tick();
    check("R9 restart new word", pulse_o, 0);
    start_i = 1'b0;
    tick();
    tick();
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    test_reset();
    test_ability();
    test_flp_basic();
    test_flp_dense();
    test_nlp();
    test_mode_switch();
    test_stop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule